// File: doc/BRIEF.md
# Byte-Wide Handshake Link, Device End

This block terminates a slow, byte-wide, two-way link driven by a host controller. The host toggles a link clock from software, pulls a link reset, and runs two separate handshakes: for bytes flowing toward the device it drives data and a valid line and reads back a device ready line; for bytes flowing toward the host the device drives data and a valid line and the host answers with a ready line. The two directions share only the link clock and reset, so a byte may move each way on the same link clock edge.

Everything from the host is treated as asynchronous. It is resynchronized into the fast local clock, and a rising edge of the resynchronized link clock acts as the single transfer event. On the local side the block offers an ordinary valid/ready byte stream in each direction. Each direction holds one byte: a received byte is kept until local logic takes it, and a byte handed in for sending is kept until the host has acknowledged it.

Top module: `byte_link_dev`

## Requirements
- R1: On a rising link clock edge with host-valid high and device-ready high, the byte on the inbound data pins is captured and presented on `rx_data_o` with `rx_valid_o` high.
- R2: While a received byte is held, device-ready stays low and later link clock edges, even with host-valid high, leave the held byte unchanged.
- R3: When local logic takes the held byte (`rx_valid_o` and `rx_ready_i` both high on a clock edge), `rx_valid_o` falls and device-ready rises again.
- R4: A rising link clock edge with host-valid low captures nothing.
- R5: A local byte offered while `tx_ready_o` is high is driven on the outbound data pins with device-valid high; `tx_ready_o` stays low and the pins stay stable until the host accepts it.
- R6: A rising link clock edge with host-ready high ends an outbound transfer: device-valid falls and `tx_ready_o` rises. An edge with host-ready low leaves device-valid high.
- R7: An inbound capture and an outbound completion can happen on the same link clock edge.
- R8: While link reset is high, device-ready, device-valid, `rx_valid_o` and `tx_ready_o` are all low and any held byte in either direction is dropped; after it falls both directions are empty and ready.
- R9: A falling link clock edge never causes a transfer in either direction.
- R10: After local reset, device-ready and `tx_ready_o` are high and device-valid and `rx_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local fast clock |
| rst_ni | input | 1 | Local asynchronous active-low reset |
| lnk_clk_i | input | 1 | Software-generated link clock from the host |
| lnk_rst_i | input | 1 | Link reset from the host, active high |
| lnk_din_i | input | 8 | Inbound data byte from the host |
| lnk_hvalid_i | input | 1 | Host has placed a valid inbound byte |
| lnk_dready_o | output | 1 | Device can accept an inbound byte |
| lnk_dout_o | output | 8 | Outbound data byte to the host |
| lnk_dvalid_o | output | 1 | Device has placed a valid outbound byte |
| lnk_hready_i | input | 1 | Host can accept an outbound byte |
| rx_data_o | output | 8 | Received byte to local logic |
| rx_valid_o | output | 1 | Received byte is held |
| rx_ready_i | input | 1 | Local logic takes the received byte |
| tx_data_i | input | 8 | Byte from local logic to send |
| tx_valid_i | input | 1 | Local logic offers a byte |
| tx_ready_o | output | 1 | Block can take a byte to send |

## Verification
The bench drives a second inbound byte while the first is still held; a design that ignored its own ready would overwrite the byte and local logic would read the wrong value. It lowers the link clock while host-valid is high, which a design detecting any edge instead of the rising one would turn into a spurious capture. It holds an outbound byte across a link clock edge with host-ready low, where a design that completed on the edge alone would drop device-valid early, and it fires both directions on one edge to catch a design that serializes them. Finally it asserts link reset with a byte held each way; a design that kept either byte would still show valid after release.

// File: rtl/link_pkg.sv
package link_pkg;
  parameter int unsigned LINK_BYTE_W = 8;
  parameter int unsigned LINK_SYNC_N = 2;

  // Host control lines that cross into the local clock domain.
  typedef struct packed {
    logic lclk;
    logic lrst;
    logic hvalid;
    logic hready;
  } link_ctl_t;

  localparam int unsigned LINK_CTL_W = $bits(link_ctl_t);
endpackage

// File: rtl/link_sync.sv
module link_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/link_rx.sv
module link_rx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lrst_i,
  input  logic              rise_i,
  input  logic              hvalid_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              dready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;
  logic              cap_en, pop_en;

  assign dready_o   = ~full_q & ~lrst_i;
  assign cap_en     = rise_i & hvalid_i & dready_o;
  assign pop_en     = full_q & rx_ready_i;
  assign rx_valid_o = full_q;
  assign rx_data_o  = data_q;

  always_comb begin
    full_d = full_q;
    if (lrst_i)      full_d = 1'b0;
    else if (cap_en) full_d = 1'b1;
    else if (pop_en) full_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else         full_q <= full_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (cap_en) data_q <= din_i;
  end

  // R2
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !rx_ready_i && !lrst_i) |=> (rx_valid_o && $stable(rx_data_o)));
  // R3
  rx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rx_ready_i && !lrst_i) |=> (!rx_valid_o && dready_o));
  // R8
  rx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrst_i |=> !rx_valid_o);
endmodule

// File: rtl/link_tx.sv
module link_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lrst_i,
  input  logic              rise_i,
  input  logic              hready_i,
  output logic              dvalid_o,
  output logic [DATA_W-1:0] dout_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);
  logic              busy_q, busy_d;
  logic [DATA_W-1:0] hold_q;
  logic              load_en, done_en;

  assign tx_ready_o = ~busy_q & ~lrst_i;
  assign load_en    = tx_valid_i & tx_ready_o;
  assign done_en    = busy_q & rise_i & hready_i;
  assign dvalid_o   = busy_q;
  assign dout_o     = hold_q;

  always_comb begin
    busy_d = busy_q;
    if (lrst_i)       busy_d = 1'b0;
    else if (load_en) busy_d = 1'b1;
    else if (done_en) busy_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (load_en) hold_q <= tx_data_i;
  end

  // R5
  tx_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvalid_o && !lrst_i) |=> ($stable(dout_o) && !tx_ready_o || !dvalid_o));
  // R6
  tx_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvalid_o && !(rise_i && hready_i) && !lrst_i) |=> dvalid_o);
  // R6
  tx_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvalid_o && rise_i && hready_i && !lrst_i) |=> (!dvalid_o && tx_ready_o));
endmodule

// File: rtl/byte_link_dev.sv
module byte_link_dev
  import link_pkg::*;
#(
  parameter int unsigned DATA_W = LINK_BYTE_W,
  parameter int unsigned SYNC_N = LINK_SYNC_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lnk_clk_i,
  input  logic              lnk_rst_i,
  input  logic [DATA_W-1:0] lnk_din_i,
  input  logic              lnk_hvalid_i,
  output logic              lnk_dready_o,
  output logic [DATA_W-1:0] lnk_dout_o,
  output logic              lnk_dvalid_o,
  input  logic              lnk_hready_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);
  localparam int unsigned BUS_W = LINK_CTL_W + DATA_W;

  link_ctl_t         ctl_raw, ctl_s;
  logic [DATA_W-1:0] din_s;
  logic [BUS_W-1:0]  bus_s;
  logic              lclk_q;
  logic              rise;

  assign ctl_raw = '{lclk: lnk_clk_i, lrst: lnk_rst_i,
                     hvalid: lnk_hvalid_i, hready: lnk_hready_i};

  // Data travels with the control lines so both arrive in the same cycle.
  link_sync #(.WIDTH(BUS_W), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({ctl_raw, lnk_din_i}),
    .sync_o (bus_s)
  );

  assign ctl_s = bus_s[BUS_W-1 -: LINK_CTL_W];
  assign din_s = bus_s[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lclk_q <= 1'b0;
    else         lclk_q <= ctl_s.lclk;
  end

  assign rise = ctl_s.lclk & ~lclk_q;

  link_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lrst_i    (ctl_s.lrst),
    .rise_i    (rise),
    .hvalid_i  (ctl_s.hvalid),
    .din_i     (din_s),
    .dready_o  (lnk_dready_o),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o),
    .rx_ready_i(rx_ready_i)
  );

  link_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lrst_i    (ctl_s.lrst),
    .rise_i    (rise),
    .hready_i  (ctl_s.hready),
    .dvalid_o  (lnk_dvalid_o),
    .dout_o    (lnk_dout_o),
    .tx_data_i (tx_data_i),
    .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o)
  );

  // R9
  fall_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_s.lclk && !ctl_s.lrst && !rx_ready_i && !tx_valid_i)
      |=> ($stable(rx_valid_o) && $stable(lnk_dvalid_o)));
  // R8
  link_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_s.lrst |-> (!lnk_dready_o && !tx_ready_o));
endmodule

// File: tb/byte_link_dev_bench.sv
module byte_link_dev_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lnk_clk_i = 1'b0;
  logic       lnk_rst_i = 1'b0;
  logic [7:0] lnk_din_i = 8'h00;
  logic       lnk_hvalid_i = 1'b0;
  logic       lnk_dready_o;
  logic [7:0] lnk_dout_o;
  logic       lnk_dvalid_o;
  logic       lnk_hready_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;
  logic       rx_ready_i = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  byte_link_dev u_byte_link_dev (
    .clk_i, .rst_ni, .lnk_clk_i, .lnk_rst_i, .lnk_din_i, .lnk_hvalid_i,
    .lnk_dready_o, .lnk_dout_o, .lnk_dvalid_o, .lnk_hready_i,
    .rx_data_o, .rx_valid_o, .rx_ready_i, .tx_data_i, .tx_valid_i, .tx_ready_o
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic link_pulse();
    idle(4);
    lnk_clk_i = 1'b1;
    idle(8);
    lnk_clk_i = 1'b0;
    idle(8);
  endtask

  task automatic consume();
    @(negedge clk_i) rx_ready_i = 1'b1;
    @(negedge clk_i) rx_ready_i = 1'b0;
    idle(2);
  endtask

  task automatic offer(input logic [7:0] b);
    @(negedge clk_i);
    tx_data_i  = b;
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(lnk_dready_o, 1, "R10 dready after reset");
    chk(tx_ready_o,   1, "R10 tx_ready after reset");
    chk(lnk_dvalid_o, 0, "R10 dvalid after reset");
    chk(rx_valid_o,   0, "R10 rx_valid after reset");
  endtask

  task automatic t_rx_basic();
    lnk_din_i = 8'hA5; lnk_hvalid_i = 1'b1;
    link_pulse();
    lnk_hvalid_i = 1'b0;
    chk(rx_valid_o, 1, "R1 rx_valid after capture");
    chk(rx_data_o, 8'hA5, "R1 captured byte");
    chk(lnk_dready_o, 0, "R2 dready low while held");
  endtask

  task automatic t_rx_hold();
    lnk_din_i = 8'h3C; lnk_hvalid_i = 1'b1;
    link_pulse();
    lnk_hvalid_i = 1'b0;
    chk(rx_data_o, 8'hA5, "R2 held byte not overwritten");
    consume();
    chk(rx_valid_o, 0, "R3 rx_valid after take");
    chk(lnk_dready_o, 1, "R3 dready after take");
  endtask

  task automatic t_rx_novalid();
    lnk_din_i = 8'h77; lnk_hvalid_i = 1'b0;
    link_pulse();
    chk(rx_valid_o, 0, "R4 no capture without host valid");
    chk(lnk_dready_o, 1, "R4 dready stays high");
  endtask

  task automatic t_fall();
    lnk_hvalid_i = 1'b0; lnk_din_i = 8'h11;
    idle(4); lnk_clk_i = 1'b1; idle(8);
    lnk_hvalid_i = 1'b1; idle(6);
    lnk_clk_i = 1'b0; idle(8);
    chk(rx_valid_o, 0, "R9 falling edge captures nothing");
    lnk_hvalid_i = 1'b0; idle(4);
  endtask

  task automatic t_tx();
    offer(8'h5A);
    chk(lnk_dvalid_o, 1, "R5 dvalid after offer");
    chk(lnk_dout_o, 8'h5A, "R5 outbound byte");
    chk(tx_ready_o, 0, "R5 tx_ready low while busy");
    lnk_hready_i = 1'b0;
    link_pulse();
    chk(lnk_dvalid_o, 1, "R6 dvalid held without host ready");
    chk(lnk_dout_o, 8'h5A, "R5 outbound byte stable");
    lnk_hready_i = 1'b1;
    link_pulse();
    lnk_hready_i = 1'b0;
    chk(lnk_dvalid_o, 0, "R6 dvalid after host ready");
    chk(tx_ready_o, 1, "R6 tx_ready after completion");
  endtask

  task automatic t_duplex();
    offer(8'hC3);
    lnk_din_i = 8'h96; lnk_hvalid_i = 1'b1; lnk_hready_i = 1'b1;
    link_pulse();
    lnk_hvalid_i = 1'b0; lnk_hready_i = 1'b0;
    chk(rx_valid_o, 1, "R7 inbound on shared edge");
    chk(rx_data_o, 8'h96, "R7 inbound byte");
    chk(lnk_dvalid_o, 0, "R7 outbound done on shared edge");
    consume();
  endtask

  task automatic t_lreset();
    offer(8'h81);
    lnk_din_i = 8'h42; lnk_hvalid_i = 1'b1;
    link_pulse();
    lnk_hvalid_i = 1'b0;
    chk(rx_valid_o, 1, "R1 byte held before link reset");
    lnk_rst_i = 1'b1; idle(6);
    chk(lnk_dvalid_o, 0, "R8 dvalid during link reset");
    chk(rx_valid_o, 0, "R8 rx byte dropped");
    chk(lnk_dready_o, 0, "R8 dready during link reset");
    chk(tx_ready_o, 0, "R8 tx_ready during link reset");
    lnk_rst_i = 1'b0; idle(6);
    chk(lnk_dready_o, 1, "R8 dready after link reset");
    chk(tx_ready_o, 1, "R8 tx_ready after link reset");
    chk(rx_valid_o, 0, "R8 rx empty after link reset");
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(4);
    t_reset();
    t_rx_basic();
    t_rx_hold();
    t_rx_novalid();
    t_fall();
    t_tx();
    t_duplex();
    t_lreset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule